// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM that runs four-word bursts. Each word has two byte lanes, and each lane holds 8 data bits plus 1 parity bit, so a word is 18 bits. The address, the chip selects, the strobes, the write controls and the write data are all captured on the rising clock edge. The memory array is then written or read from those registered values one edge later.

Either of two active-low address strobes starts a burst. After that, an active-low advance input steps a 2-bit burst counter. The counter wraps through four words in either linear or interleaved order. When the advance input is high and no strobe is low, the block repeats the access at the current burst address. Read data appears one clock after its address is registered. The bus is driven only while the asynchronous output enable is low and the pipeline holds a read. A deselect stops the drive at the very next edge, with no extra cycle of driven data.

A tristate pad is not modelled. `dOutDrive` marks the cycles in which the bus would be driven, and `dOut` reads zero in all other cycles.

Top module: `pipeBurstSram`

## Requirements
- R1: The device counts as selected only when `selPrimN`=0, `selHigh`=1 and `selLowN`=0. An accepted strobe while the device is not selected ends any burst and performs no access: no array write, and no drive on the following cycles.
- R2: `procStrobeN`=0 with `selPrimN`=0 starts a read burst at `addr`. When `selPrimN`=1, `procStrobeN` is ignored and a burst in progress continues.
- R3: `ctrlStrobeN`=0 starts a burst at `addr` whatever the state of `selPrimN`. The first access is a write if any write control is active, and a read otherwise. With `selPrimN`=1 the same strobe deselects the device and ends the burst.
- R4: When both strobes are low and `procStrobeN` is accepted, the access is a read and no lane is written, whatever the write controls are.
- R5: With `burstMode`=0 captured at the burst start (linear order), each cycle with `advanceN`=0 adds 1 modulo 4 to the low 2 address bits. The upper address bits stay those of the start address.
- R6: With `burstMode`=1 captured at the burst start (interleaved order), the low 2 address bits of the k-th word (k = 0..3, wrapping) are the starting low bits XOR k.
- R7: In a cycle with no accepted strobe and `advanceN`=1, an active burst repeats its access at the same address.
- R8: `laneEnN[0]`=0 writes bits [8:0] (lane 0 data plus parity). `laneEnN[1]`=0 writes bits [17:9]. A lane whose enable is high keeps its contents.
- R9: `globalWrN`=0 writes both lanes, whatever `laneEnN` is.
- R10: Data for a read registered at edge N is driven after edge N+1. A read registered on the edge right after a write to the same address returns the new data.
- R11: `dOutDrive` equals (read data pending) AND NOT `outEnN`, and it follows `outEnN` without waiting for a clock edge. `dOut` is zero whenever `dOutDrive` is 0.
- R12: A deselect registered on the edge right after a read lets that read's data drive for exactly one cycle. The bus is undriven after the following edge.
- R13: While `rstN` is low and right after it rises, no burst is active and the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| addr | input | AddrWidth | External word address |
| procStrobeN | input | 1 | Processor-side burst start strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side burst start strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| selPrimN | input | 1 | Primary chip select, active low |
| selHigh | input | 1 | Secondary chip select, active high |
| selLowN | input | 1 | Secondary chip select, active low |
| globalWrN | input | 1 | Write-all-lanes control, active low |
| laneEnN | input | 2 | Per-lane write enables, active low |
| burstMode | input | 1 | Burst order: 1 interleaved, 0 linear |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dIn | input | 18 | Write data, lane 1 in [17:9], lane 0 in [8:0] |
| dOut | output | 18 | Read data, zero when not driven |
| dOutDrive | output | 1 | High when the data bus is driven |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words) and 9-bit lanes. With these values every word can be preloaded with a known pattern in a few hundred cycles. Bursts then wrap at every 4-word boundary, and random addresses hit both burst orders, suspends and restarts densely across the whole array. Directed sequences pin down the exact word order for each burst mode. They also cover the one-cycle deselect tail, partial-lane writes and strobe priority. Several thousand random cycles are compared against a reference model of the protocol kept in the bench.

// File: rtl/burstSramPkg.sv
package burstSramPkg;
  localparam int LaneCount = 2;

  typedef struct packed {
    logic                 access;
    logic                 isRead;
    logic [LaneCount-1:0] laneWr;
  } accessStrobe_t;

  // low address bits of burst step 'step' from starting bits 'startLow'
  function automatic logic [1:0] burstOffset(input logic [1:0] startLow,
                                             input logic [1:0] step,
                                             input logic interleave);
    return interleave ? (startLow ^ step) : (startLow + step);
  endfunction
endpackage

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstSramPkg::*;
#(
  parameter int AddrWidth = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [AddrWidth-1:0] addr,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 selPrimN,
  input  logic                 selHigh,
  input  logic                 selLowN,
  input  logic                 globalWrN,
  input  logic [LaneCount-1:0] laneEnN,
  input  logic                 burstMode,
  output accessStrobe_t        strb,
  output logic [AddrWidth-1:0] accessAddr
);
  logic                 selected, procTake, startReq;
  logic [LaneCount-1:0] laneReq;
  logic                 burstActive, burstIlv;
  logic [AddrWidth-1:0] baseAddr;
  logic [1:0]           burstCnt, stepCnt;

  accessStrobe_t        strbNext;
  logic [AddrWidth-1:0] addrNext, baseNext;
  logic                 activeNext, ilvNext;
  logic [1:0]           cntNext;

  always_comb begin
    selected = !selPrimN && selHigh && !selLowN;
    procTake = !procStrobeN && !selPrimN;
    startReq = procTake || !ctrlStrobeN;
    laneReq  = globalWrN ? ~laneEnN : '1;
    stepCnt  = advanceN ? burstCnt : burstCnt + 2'd1;

    strbNext   = '0;
    addrNext   = accessAddr;
    baseNext   = baseAddr;
    activeNext = burstActive;
    ilvNext    = burstIlv;
    cntNext    = burstCnt;

    if (startReq) begin
      activeNext = selected;
      if (selected) begin
        baseNext        = addr;
        ilvNext         = burstMode;
        cntNext         = 2'd0;
        addrNext        = addr;
        strbNext.access = 1'b1;
        strbNext.laneWr = procTake ? '0 : laneReq;
        strbNext.isRead = procTake || (laneReq == '0);
      end
    end else if (burstActive) begin
      cntNext         = stepCnt;
      addrNext        = {baseAddr[AddrWidth-1:2], burstOffset(baseAddr[1:0], stepCnt, burstIlv)};
      strbNext.access = 1'b1;
      strbNext.laneWr = laneReq;
      strbNext.isRead = (laneReq == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strb        <= '0;
      accessAddr  <= '0;
      baseAddr    <= '0;
      burstActive <= 1'b0;
      burstIlv    <= 1'b0;
      burstCnt    <= 2'd0;
    end else begin
      strb        <= strbNext;
      accessAddr  <= addrNext;
      baseAddr    <= baseNext;
      burstActive <= activeNext;
      burstIlv    <= ilvNext;
      burstCnt    <= cntNext;
    end
  end

  // R4: an accepted processor strobe on a selected device is always a read
  p_proc_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !selPrimN && selHigh && !selLowN)
    |=> (strb.access && strb.isRead && strb.laneWr == '0))
    else $error("p_proc_read_r4");

  // R1: a strobe while not selected produces no access
  p_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    (((!procStrobeN && !selPrimN) || !ctrlStrobeN) && !(!selPrimN && selHigh && !selLowN))
    |=> !strb.access)
    else $error("p_deselect_r1");

  // R5: linear advance steps low bits by one, upper bits fixed
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !startReq && !advanceN && !burstIlv)
    |=> (accessAddr[1:0] == $past(accessAddr[1:0]) + 2'd1)
        && (accessAddr[AddrWidth-1:2] == $past(accessAddr[AddrWidth-1:2])))
    else $error("p_linear_step_r5");

  // R7: suspend repeats the same address
  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && !startReq && advanceN) |=> (strb.access && $stable(accessAddr)))
    else $error("p_suspend_hold_r7");

  // R9: global write on a controller-started access writes both lanes
  p_global_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!globalWrN && procStrobeN && !ctrlStrobeN && !selPrimN && selHigh && !selLowN)
    |=> (strb.laneWr == '1 && !strb.isRead))
    else $error("p_global_wr_r9");
endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import burstSramPkg::*;
#(
  parameter int AddrWidth = 6,
  parameter int LaneBits  = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  accessStrobe_t                 strb,
  input  logic [AddrWidth-1:0]          accessAddr,
  input  logic [LaneBits*LaneCount-1:0] dIn,
  input  logic                          outEnN,
  output logic [LaneBits*LaneCount-1:0] dOut,
  output logic                          dOutDrive
);
  localparam int WordBits = LaneBits * LaneCount;
  localparam int Depth    = 1 << AddrWidth;

  logic [WordBits-1:0] wrData, rdData;
  logic                outValid;

  always_ff @(posedge clk) wrData <= dIn;

  for (genvar lane = 0; lane < LaneCount; lane++) begin : gLane
    logic [LaneBits-1:0] laneMem [Depth];
    logic [LaneBits-1:0] rdLane;
    always_ff @(posedge clk) begin
      if (strb.access && strb.laneWr[lane])
        laneMem[accessAddr] <= wrData[lane*LaneBits +: LaneBits];
      if (strb.access && strb.isRead)
        rdLane <= laneMem[accessAddr];
    end
    assign rdData[lane*LaneBits +: LaneBits] = rdLane;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strb.access && strb.isRead;
  end

  assign dOutDrive = outValid && !outEnN;
  assign dOut      = dOutDrive ? rdData : '0;

  // R12: no pending access means the bus is released after the next edge
  p_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.access |=> !dOutDrive)
    else $error("p_release_r12");

  // R10: a registered read drives one edge later unless output is disabled
  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && strb.isRead) |=> (outEnN || dOutDrive))
    else $error("p_read_latency_r10");

  // R11: undriven bus reads zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !dOutDrive |-> (dOut == '0))
    else $error("p_idle_zero_r11");
endmodule

// File: rtl/pipeBurstSram.sv
module pipeBurstSram
  import burstSramPkg::*;
#(
  parameter int AddrWidth = 6,
  parameter int LaneBits  = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [AddrWidth-1:0]          addr,
  input  logic                          procStrobeN,
  input  logic                          ctrlStrobeN,
  input  logic                          advanceN,
  input  logic                          selPrimN,
  input  logic                          selHigh,
  input  logic                          selLowN,
  input  logic                          globalWrN,
  input  logic [LaneCount-1:0]          laneEnN,
  input  logic                          burstMode,
  input  logic                          outEnN,
  input  logic [LaneBits*LaneCount-1:0] dIn,
  output logic [LaneBits*LaneCount-1:0] dOut,
  output logic                          dOutDrive
);
  accessStrobe_t        strb;
  logic [AddrWidth-1:0] accessAddr;

  burstCtrl #(.AddrWidth(AddrWidth)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .selPrimN(selPrimN), .selHigh(selHigh), .selLowN(selLowN),
    .globalWrN(globalWrN), .laneEnN(laneEnN), .burstMode(burstMode),
    .strb(strb), .accessAddr(accessAddr)
  );

  sramDatapath #(.AddrWidth(AddrWidth), .LaneBits(LaneBits)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .accessAddr(accessAddr),
    .dIn(dIn), .outEnN(outEnN), .dOut(dOut), .dOutDrive(dOutDrive)
  );
endmodule

// File: tb/tb_pipeBurstSram.sv
module tb_pipeBurstSram;
  logic clk = 1'b0;
  logic rstN;
  logic [5:0] addr;
  logic procStrobeN, ctrlStrobeN, advanceN, selPrimN, selHigh, selLowN;
  logic globalWrN, burstMode, outEnN;
  logic [1:0] laneEnN;
  logic [17:0] dIn, dOut;
  logic dOutDrive;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipeBurstSram dut (
    .clk(clk), .rstN(rstN), .addr(addr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .selPrimN(selPrimN),
    .selHigh(selHigh), .selLowN(selLowN), .globalWrN(globalWrN),
    .laneEnN(laneEnN), .burstMode(burstMode), .outEnN(outEnN),
    .dIn(dIn), .dOut(dOut), .dOutDrive(dOutDrive)
  );

  function automatic logic [17:0] pat(input logic [5:0] a);
    return 18'((32'(a) * 32'h2B5 + 32'h1F3) & 32'h3FFFF);
  endfunction

  function automatic logic [1:0] ordOf(input logic [1:0] s, input logic [1:0] k, input logic ilv);
    return ilv ? (s ^ k) : 2'(s + k);
  endfunction

  // reference model of the protocol
  logic [17:0] mMem [64];
  logic mActive, mIlv, pAcc, pRead, expValid;
  logic [5:0] mBase, pAddr;
  logic [1:0] mCnt, pLane;
  logic [17:0] pData, expData;

  always @(posedge clk) begin
    logic sel, procOk, start;
    logic [1:0] lanes, nc;
    if (!rstN) begin
      mActive <= 1'b0; pAcc <= 1'b0; expValid <= 1'b0; mCnt <= 2'd0;
    end else begin
      if (pAcc) begin
        if (pLane[0]) mMem[pAddr][8:0]  <= pData[8:0];
        if (pLane[1]) mMem[pAddr][17:9] <= pData[17:9];
        expValid <= pRead;
        if (pRead) expData <= mMem[pAddr];
      end else expValid <= 1'b0;
      sel    = !selPrimN && selHigh && !selLowN;
      procOk = !procStrobeN && !selPrimN;
      start  = procOk || !ctrlStrobeN;
      lanes  = globalWrN ? ~laneEnN : 2'b11;
      if (start) begin
        mActive <= sel;
        pAcc    <= sel;
        if (sel) begin
          mBase <= addr; mIlv <= burstMode; mCnt <= 2'd0; pAddr <= addr;
          pRead <= procOk || (lanes == 2'b00);
          pLane <= procOk ? 2'b00 : lanes;
        end
      end else if (mActive) begin
        nc = advanceN ? mCnt : 2'(mCnt + 2'd1);
        mCnt  <= nc;
        pAddr <= {mBase[5:2], ordOf(mBase[1:0], nc, mIlv)};
        pAcc  <= 1'b1;
        pRead <= (lanes == 2'b00);
        pLane <= lanes;
      end else pAcc <= 1'b0;
    end
    pData <= dIn;
  end

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic want(input string tag, input logic drv, input logic [17:0] data);
    check(tag, {dOutDrive, dOut}, {drv, drv ? data : 18'h0});
  endtask

  task automatic tick();
    logic ed;
    @(posedge clk);
    @(negedge clk);
    ed = expValid && !outEnN;
    check("R10 R11 model", {dOutDrive, dOut}, {ed, ed ? expData : 18'h0});
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    selPrimN = 1'b0; selHigh = 1'b1; selLowN = 1'b0;
    globalWrN = 1'b1; laneEnN = 2'b11; outEnN = 1'b0; burstMode = 1'b0;
  endtask

  task automatic flush();
    idle(); ctrlStrobeN = 1'b0; selHigh = 1'b0; tick();
    idle(); tick(); tick();
  endtask

  task automatic burstRead(input logic [5:0] a, input logic ilv, input logic [1:0] k0, input logic [1:0] k1,
                           input logic [1:0] k2, input logic [1:0] k3, input string tag);
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = a; burstMode = ilv; tick();
    want("R10 no data before latency", 1'b0, 18'h0);
    idle(); burstMode = ~ilv; advanceN = 1'b0;
    tick(); want(tag, 1'b1, pat({a[5:2], k0}));
    tick(); want(tag, 1'b1, pat({a[5:2], k1}));
    tick(); want(tag, 1'b1, pat({a[5:2], k2}));
    advanceN = 1'b1;
    tick(); want(tag, 1'b1, pat({a[5:2], k3}));
    tick(); want("R7 suspend repeats", 1'b1, pat({a[5:2], k3}));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd2024);
    idle(); addr = '0; dIn = '0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    want("R13 reset undriven", 1'b0, 18'h0);
    rstN = 1'b1;
    tick(); want("R13 after reset undriven", 1'b0, 18'h0);

    // preload every word with pat(address)
    for (int b = 0; b < 64; b += 4) begin
      idle(); ctrlStrobeN = 1'b0; globalWrN = 1'b0; addr = 6'(b); dIn = pat(6'(b)); tick();
      for (int k = 1; k < 4; k++) begin
        idle(); advanceN = 1'b0; globalWrN = 1'b0; dIn = pat(6'(b + k)); tick();
      end
    end

    // R5 linear from 5: 5,6,7,4 ; R6 interleaved from 5: 5,4,7,6
    burstRead(6'd5, 1'b0, 2'd1, 2'd2, 2'd3, 2'd0, "R5 linear order");
    burstRead(6'd5, 1'b1, 2'd1, 2'd0, 2'd3, 2'd2, "R6 interleaved order");

    // R12 single-cycle deselect
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd9; tick();
    idle(); ctrlStrobeN = 1'b0; selHigh = 1'b0; tick();
    want("R12 read data one cycle", 1'b1, pat(6'd9));
    idle(); tick();
    want("R12 released after deselect", 1'b0, 18'h0);

    // R11 asynchronous output enable
    idle(); ctrlStrobeN = 1'b0; addr = 6'd10; tick();
    idle(); tick();
    want("R11 driven with enable low", 1'b1, pat(6'd10));
    outEnN = 1'b1; #1;
    want("R11 enable high releases", 1'b0, 18'h0);
    outEnN = 1'b0; #1;
    want("R11 enable low drives again", 1'b1, pat(6'd10));

    // R2 processor strobe ignored with primary select high
    flush();
    idle(); procStrobeN = 1'b0; addr = 6'd12; tick();
    idle(); procStrobeN = 1'b0; selPrimN = 1'b1; addr = 6'd40; advanceN = 1'b0; tick();
    want("R2 proc read data", 1'b1, pat(6'd12));
    idle(); advanceN = 1'b0; tick();
    want("R2 ignored strobe, burst continues", 1'b1, pat(6'd13));

    // R3 controller strobe honoured with primary select high -> deselect
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd16; tick();
    idle(); ctrlStrobeN = 1'b0; selPrimN = 1'b1; advanceN = 1'b0; tick();
    want("R3 first read", 1'b1, pat(6'd16));
    idle(); advanceN = 1'b0; tick();
    want("R3 ctrl strobe deselected", 1'b0, 18'h0);

    // R8 lane 0 only write
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd20; laneEnN = 2'b10; dIn = 18'h3FFFF; tick();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd20; tick();
    idle(); tick();
    want("R8 lane 0 written lane 1 kept", 1'b1, {pat(6'd20)[17:9], 9'h1FF});

    // R9 global write overrides lane enables
    idle(); ctrlStrobeN = 1'b0; addr = 6'd21; globalWrN = 1'b0; dIn = 18'h15A5A; tick();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd21; tick();
    want("R10 write access not driven", 1'b0, 18'h0);
    idle(); tick();
    want("R9 global write both lanes", 1'b1, 18'h15A5A);

    // R4 both strobes low -> read, no write
    flush();
    idle(); procStrobeN = 1'b0; ctrlStrobeN = 1'b0; addr = 6'd22;
    globalWrN = 1'b0; laneEnN = 2'b00; dIn = 18'h0; tick();
    idle(); tick();
    want("R4 priority read", 1'b1, pat(6'd22));
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd22; tick();
    idle(); tick();
    want("R4 memory unchanged", 1'b1, pat(6'd22));

    // R1 not selected: no access, no write
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd25; selLowN = 1'b1; globalWrN = 1'b0; dIn = 18'h0; tick();
    idle(); tick();
    want("R1 no drive when not selected", 1'b0, 18'h0);
    idle(); procStrobeN = 1'b0; addr = 6'd25; selHigh = 1'b0; tick();
    idle(); tick();
    want("R1 proc strobe not selected", 1'b0, 18'h0);
    idle(); ctrlStrobeN = 1'b0; addr = 6'd25; tick();
    idle(); tick();
    want("R1 write suppressed", 1'b1, pat(6'd25));

    // R10 write followed at once by read
    flush();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd30; globalWrN = 1'b0; dIn = 18'h2C3D1; tick();
    idle(); ctrlStrobeN = 1'b0; addr = 6'd30; tick();
    idle(); tick();
    want("R10 read after write", 1'b1, 18'h2C3D1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      procStrobeN = (r[2:0] != 3'd0);
      ctrlStrobeN = (r[5:3] != 3'd0);
      advanceN    = (r[8:6] < 3'd2);
      selPrimN    = (r[12:9] == 4'd0);
      selHigh     = (r[16:13] != 4'd0);
      selLowN     = (r[20:17] == 4'd0);
      globalWrN   = (r[24:21] != 4'd0);
      laneEnN     = (r[26:25] == 2'd0) ? r[28:27] : 2'b11;
      outEnN      = (r[31:29] == 3'd0);
      burstMode   = 1'($urandom);
      addr        = 6'($urandom);
      dIn         = 18'($urandom);
      tick();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule